// File: doc/BRIEF.md
# Accumulator CPU With RAM-Resident Registers

This block is a small instruction-level processor built around an 8-bit accumulator. Every opcode is one byte. There is no register file. All 32 registers are the first 32 bytes of a byte-wide single-port RAM. The 16-bit instruction pointer is one of them: its low byte is at address 0 and its high byte at address 1. Each instruction is handled by a multi-cycle state machine, in this order:

1. Read the pointer from RAM.
2. Fetch the opcode.
3. Write the incremented pointer back.
4. Run the operation.

An opcode's upper five bits name a register, and its lower bits pick the operation. The operations are add with carry-out, AND, XOR, load, store, an indirect load and an indirect store, a nibble-shift literal, an exchange with the I/O ports, and a conditional jump.

A test harness loads a program through a backdoor RAM port while reset is held, then releases reset. The harness waits for the halt flag, which rises when a taken jump targets its own address. It then reads RAM back through the same backdoor port. The RAM keeps only the low `MEM_AW` address bits, so higher addresses wrap.

Top module: `regram_cpu`

## Requirements
- R1: While reset is held, `out_port` is 0 and `halt` is 0.
- R2: The pointer in RAM bytes 0 (low) and 1 (high) gives the fetch address. It is incremented by one as a full 16-bit value, carrying from byte 0 into byte 1, and written back before the operation runs. Instructions therefore execute in address order, including across a 256-byte boundary.
- R3: For opcode bits [2:0]=000, the block writes (X + [r]) mod 256 to [r] and sets X to the carry-out (0 or 1). Here r is opcode bits [7:3].
- R4: Opcode bits [2:0]=100 sets X to X AND [r]. Bits 010 sets X to X XOR [r]. Bits 110 sets X to [r].
- R5: Opcode bits [2:0]=001 writes X to [r] and leaves X unchanged.
- R6: Opcode bits [2:0]=101 sets X to the byte at address {X, [r]}, with X as the high byte.
- R7: Opcode bits [3:0]=0011 writes X to address {[r+1], [r]}. The form is defined for even r only.
- R8: Opcode bits [3:0]=1011 copies X to `out_port`, then sets X to {6'b0, `in_bits`}. `out_port` changes on no other opcode.
- R9: Opcode bits [3:0]=0111 sets X to {opcode[7:4], X[7:4]}.
- R10: Opcode bits [3:0]=1111 is a conditional jump. When X is 0, the pointer becomes {[r], [2]}, with [r] as the high byte, and is stored back to bytes 0 and 1. When X is nonzero, execution continues with the next byte.
- R11: A taken jump whose target equals its own address raises `halt`. `halt` then stays high and the block stops until reset.
- R12: When `bd_en` is high, the backdoor drives the RAM port and a write is performed if `bd_we` is high. `bd_rdata` returns the byte at `bd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_bits | input | 2 | Two-bit input port |
| out_port | output | 8 | Output latch written by the I/O opcode |
| halt | output | 1 | Self-jump detected; block stopped |
| bd_en | input | 1 | Backdoor owns the RAM port |
| bd_we | input | 1 | Backdoor write strobe |
| bd_addr | input | 16 | Backdoor byte address |
| bd_wdata | input | 8 | Backdoor write data |
| bd_rdata | output | 8 | RAM read data, one cycle after the address |

## Verification
Accumulator results never appear at a port, so every program stores X into a register. It then zeroes X and executes a self-jump, and all checks run only after `halt` has been seen at a falling clock edge. `out_port` is read at that point too: it was set in the execute state of the I/O opcode and must hold through the remaining instructions. Each RAM byte is read through the backdoor one full clock after its address is driven, matching the one-cycle RAM read latency. The expected bytes come from arithmetic in the bench and from a bench-side copy of the whole memory. That copy is compared with the RAM once at the end, which catches stray indirect writes.

// File: rtl/regram_pkg.sv
package regram_pkg;

    localparam int DATA_W = 8;
    localparam int REG_W  = 5;
    localparam int LIT_W  = 4;

    typedef enum logic [3:0] {
        ST_PTR_LO,
        ST_PTR_HI,
        ST_FETCH,
        ST_WB_LO,
        ST_WB_HI,
        ST_EXEC,
        ST_OP1,
        ST_OP2,
        ST_OP3,
        ST_STOP
    } state_e;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_AND,
        OP_XOR,
        OP_LD,
        OP_ST,
        OP_LDI,
        OP_STI,
        OP_IO,
        OP_NIB,
        OP_JMP
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [REG_W-1:0] rsel;
        logic [LIT_W-1:0] lit;
    } dec_t;

endpackage

// File: rtl/regram_decode.sv
module regram_decode
    import regram_pkg::*;
(
    input  logic [DATA_W-1:0] ir,
    output dec_t              dec
);

    always_comb begin
        dec.rsel = ir[DATA_W-1 -: REG_W];
        dec.lit  = ir[DATA_W-1 -: LIT_W];
        case (ir[3:0])
            4'b1011: dec.op = OP_IO;
            4'b0111: dec.op = OP_NIB;
            4'b1111: dec.op = OP_JMP;
            4'b0011: dec.op = OP_STI;
            default: begin
                case (ir[2:0])
                    3'b000:  dec.op = OP_ADD;
                    3'b100:  dec.op = OP_AND;
                    3'b010:  dec.op = OP_XOR;
                    3'b110:  dec.op = OP_LD;
                    3'b001:  dec.op = OP_ST;
                    default: dec.op = OP_LDI;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/regram_alu.sv
module regram_alu
    import regram_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] m,
    output logic [DATA_W-1:0] res,
    output logic [DATA_W-1:0] sum,
    output logic              carry
);

    logic [DATA_W:0] wide;

    always_comb begin
        wide  = {1'b0, x} + {1'b0, m};
        sum   = wide[DATA_W-1:0];
        carry = wide[DATA_W];
        case (op)
            OP_AND:  res = x & m;
            OP_XOR:  res = x ^ m;
            default: res = m;
        endcase
    end

endmodule

// File: rtl/regram_ram.sv
module regram_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/regram_cpu.sv
module regram_cpu
    import regram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        in_bits,
    output logic [DATA_W-1:0] out_port,
    output logic              halt,
    input  logic              bd_en,
    input  logic              bd_we,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic [DATA_W-1:0] bd_wdata,
    output logic [DATA_W-1:0] bd_rdata
);

    localparam logic [ADDR_W-1:0] PTR_LO_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] PTR_HI_ADDR = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] JMP_LO_ADDR = ADDR_W'(2);

    typedef struct packed {
        state_e            state;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] ir;
        logic [ADDR_W-1:0] ip;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] tmp;
        logic [DATA_W-1:0] outl;
        logic              stop;
    } cpu_t;

    cpu_t cpu_q, cpu_d;
    dec_t dec;

    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic [DATA_W-1:0] ram_wdata;

    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] alu_sum;
    logic              alu_carry;
    logic [ADDR_W-1:0] ip_inc;

    regram_decode u_dec (
        .ir  (cpu_q.ir),
        .dec (dec)
    );

    regram_alu u_alu (
        .op    (dec.op),
        .x     (cpu_q.x),
        .m     (mem_rdata),
        .res   (alu_res),
        .sum   (alu_sum),
        .carry (alu_carry)
    );

    assign ip_inc = cpu_q.ip + ADDR_W'(1);

    always_comb begin
        cpu_d     = cpu_q;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (cpu_q.state)
            ST_PTR_LO: begin
                mem_addr    = PTR_LO_ADDR;
                cpu_d.state = ST_PTR_HI;
            end
            ST_PTR_HI: begin
                mem_addr        = PTR_HI_ADDR;
                cpu_d.ip[7:0]   = mem_rdata;
                cpu_d.state     = ST_FETCH;
            end
            ST_FETCH: begin
                mem_addr                 = ADDR_W'({mem_rdata, cpu_q.ip[7:0]});
                cpu_d.ip[ADDR_W-1:8]     = mem_rdata;
                cpu_d.state              = ST_WB_LO;
            end
            ST_WB_LO: begin
                cpu_d.ir    = mem_rdata;
                cpu_d.pc    = cpu_q.ip;
                cpu_d.ip    = ip_inc;
                mem_addr    = PTR_LO_ADDR;
                mem_we      = 1'b1;
                mem_wdata   = ip_inc[7:0];
                cpu_d.state = ST_WB_HI;
            end
            ST_WB_HI: begin
                mem_addr    = PTR_HI_ADDR;
                mem_we      = 1'b1;
                mem_wdata   = cpu_q.ip[ADDR_W-1:8];
                cpu_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                mem_addr    = ADDR_W'(dec.rsel);
                cpu_d.state = ST_OP1;
                case (dec.op)
                    OP_ST: begin
                        mem_we      = 1'b1;
                        mem_wdata   = cpu_q.x;
                        cpu_d.state = ST_PTR_LO;
                    end
                    OP_IO: begin
                        cpu_d.outl  = cpu_q.x;
                        cpu_d.x     = DATA_W'(in_bits);
                        cpu_d.state = ST_PTR_LO;
                    end
                    OP_NIB: begin
                        cpu_d.x     = {dec.lit, cpu_q.x[DATA_W-1:LIT_W]};
                        cpu_d.state = ST_PTR_LO;
                    end
                    OP_JMP: begin
                        if (cpu_q.x != '0) begin
                            cpu_d.state = ST_PTR_LO;
                        end
                    end
                    default: ;
                endcase
            end
            ST_OP1: begin
                cpu_d.state = ST_PTR_LO;
                case (dec.op)
                    OP_ADD: begin
                        mem_addr  = ADDR_W'(dec.rsel);
                        mem_we    = 1'b1;
                        mem_wdata = alu_sum;
                        cpu_d.x   = DATA_W'(alu_carry);
                    end
                    OP_AND, OP_XOR, OP_LD: begin
                        cpu_d.x = alu_res;
                    end
                    OP_LDI: begin
                        mem_addr    = ADDR_W'({cpu_q.x, mem_rdata});
                        cpu_d.state = ST_OP2;
                    end
                    OP_STI: begin
                        cpu_d.tmp   = mem_rdata;
                        mem_addr    = ADDR_W'(dec.rsel + REG_W'(1));
                        cpu_d.state = ST_OP2;
                    end
                    OP_JMP: begin
                        cpu_d.tmp   = mem_rdata;
                        mem_addr    = JMP_LO_ADDR;
                        cpu_d.state = ST_OP2;
                    end
                    default: ;
                endcase
            end
            ST_OP2: begin
                cpu_d.state = ST_PTR_LO;
                case (dec.op)
                    OP_LDI: begin
                        cpu_d.x = mem_rdata;
                    end
                    OP_STI: begin
                        mem_addr  = ADDR_W'({mem_rdata, cpu_q.tmp});
                        mem_we    = 1'b1;
                        mem_wdata = cpu_q.x;
                    end
                    OP_JMP: begin
                        cpu_d.ip    = ADDR_W'({cpu_q.tmp, mem_rdata});
                        mem_addr    = PTR_LO_ADDR;
                        mem_we      = 1'b1;
                        mem_wdata   = mem_rdata;
                        cpu_d.state = ST_OP3;
                    end
                    default: ;
                endcase
            end
            ST_OP3: begin
                mem_addr  = PTR_HI_ADDR;
                mem_we    = 1'b1;
                mem_wdata = cpu_q.ip[ADDR_W-1:8];
                if (cpu_q.ip == cpu_q.pc) begin
                    cpu_d.stop  = 1'b1;
                    cpu_d.state = ST_STOP;
                end else begin
                    cpu_d.state = ST_PTR_LO;
                end
            end
            ST_STOP: begin
                cpu_d.state = ST_STOP;
            end
            default: begin
                cpu_d.state = ST_PTR_LO;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_q <= '{state: ST_PTR_LO, x: '0, ir: '0, ip: '0, pc: '0,
                       tmp: '0, outl: '0, stop: 1'b0};
        end else begin
            cpu_q <= cpu_d;
        end
    end

    always_comb begin
        if (bd_en) begin
            ram_addr  = bd_addr;
            ram_we    = bd_we;
            ram_wdata = bd_wdata;
        end else begin
            ram_addr  = mem_addr;
            ram_we    = mem_we;
            ram_wdata = mem_wdata;
        end
    end

    regram_ram #(
        .AW (MEM_AW),
        .DW (DATA_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (MEM_AW'(ram_addr)),
        .wdata (ram_wdata),
        .rdata (mem_rdata)
    );

    assign out_port = cpu_q.outl;
    assign halt     = cpu_q.stop;
    assign bd_rdata = mem_rdata;

    // R2: pointer written back is the fetch address low byte plus one
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_q.state == ST_WB_LO) |->
            (mem_wdata == DATA_W'($past(mem_addr[7:0]) + 8'd1)));

    // R8: the output latch moves only on the I/O opcode
    a_r8_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_q.state == ST_EXEC && dec.op == OP_IO) |=> $stable(out_port));

    // R10: the jump target is only fetched when the accumulator is zero
    a_r10_jump_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_q.state == ST_OP2 && dec.op == OP_JMP) |-> (cpu_q.x == '0));

    // R11: halt is sticky until reset
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R12: backdoor only takes the port while the core is stopped
    a_r12_bd_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        bd_en |-> halt);

endmodule

// File: tb/regram_cpu_tb_top.sv
`timescale 1ns/1ps
module regram_cpu_tb_top;

    localparam int MEM_AW = 10;
    localparam int DEPTH  = 1 << MEM_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  in_bits = 2'b00;
    logic [7:0]  out_port;
    logic        halt;
    logic        bd_en = 1'b0;
    logic        bd_we = 1'b0;
    logic [15:0] bd_addr = '0;
    logic [7:0]  bd_wdata = '0;
    logic [7:0]  bd_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    regram_cpu #(.ADDR_W(16), .MEM_AW(MEM_AW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_bits  (in_bits),
        .out_port (out_port),
        .halt     (halt),
        .bd_en    (bd_en),
        .bd_we    (bd_we),
        .bd_addr  (bd_addr),
        .bd_wdata (bd_wdata),
        .bd_rdata (bd_rdata)
    );

    function automatic logic [7:0] val(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h7F;
            3: return 8'h80;
            4: return 8'hFF;
            5: return 8'h55;
            6: return 8'hAA;
            default: return 8'h0F;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bd_en = 1'b1; bd_we = 1'b1; bd_addr = a; bd_wdata = d;
        model[a[MEM_AW-1:0]] = d;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bd_en = 1'b1; bd_we = 1'b0; bd_addr = a;
        @(negedge clk);
        d = bd_rdata;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0; bd_en = 1'b0;
    endtask

    // common program at 0x40: LD r5; <op>; ST r7; LD r8; JMP r17 (self)
    task automatic prep(input logic [7:0] opc, input logic [7:0] a, input logic [7:0] b);
        hold_reset();
        wr(16'h0000, 8'h40); wr(16'h0001, 8'h00);
        wr(16'h0002, 8'h44); wr(16'h0011, 8'h00);
        wr(16'h0008, 8'h00); wr(16'h0005, a);
        wr(16'h0006, b);     wr(16'h0007, 8'hEE);
        wr(16'h0040, 8'h2E); wr(16'h0041, opc);
        wr(16'h0042, 8'h39); wr(16'h0043, 8'h46);
        wr(16'h0044, 8'h8F);
    endtask

    task automatic go();
        @(negedge clk);
        bd_en = 1'b0; bd_we = 1'b0; rst_n = 1'b1;
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            if (halt) break;
        end
        if (!halt) chk("R11 halt reached", 16'(halt), 16'd1);
    endtask

    initial begin
        logic [7:0] r6, r7, m, p0, p1;
        logic [8:0] s;
        int bad;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out_port in reset", 16'(out_port), 16'h0);
        chk("R1 halt in reset", 16'(halt), 16'h0);

        // R12: preload the whole RAM via backdoor
        for (int i = 0; i < DEPTH; i++) wr(16'(i), 8'((i * 37 + 11) & 8'hFF));

        // R3, R4, R5: two-operand sweeps
        for (int k = 0; k < 5; k++) begin
            for (int ai = 0; ai < 8; ai++) begin
                for (int bi = 0; bi < 8; bi++) begin
                    logic [7:0] a, b, opc;
                    a = val(ai); b = val(bi);
                    case (k)
                        0: opc = 8'h30;
                        1: opc = 8'h34;
                        2: opc = 8'h32;
                        3: opc = 8'h36;
                        default: opc = 8'h31;
                    endcase
                    prep(opc, a, b);
                    go();
                    rd(16'h0006, r6);
                    rd(16'h0007, r7);
                    s = {1'b0, a} + {1'b0, b};
                    case (k)
                        0: begin
                            chk("R3 add sum in [r]", 16'(r6), 16'(s[7:0]));
                            chk("R3 add carry in X", 16'(r7), 16'(s[8]));
                        end
                        1: chk("R4 and", 16'(r7), 16'(a & b));
                        2: chk("R4 xor", 16'(r7), 16'(a ^ b));
                        3: chk("R4 load", 16'(r7), 16'(b));
                        default: begin
                            chk("R5 store to [r]", 16'(r6), 16'(a));
                            chk("R5 X unchanged", 16'(r7), 16'(a));
                        end
                    endcase
                end
            end
        end

        // R6: indirect load from {X,[r]} (high byte keeps address above 0xFF)
        for (int ai = 0; ai < 8; ai++) begin
            for (int bi = 0; bi < 8; bi++) begin
                logic [7:0] a, b;
                logic [15:0] ea;
                a = val(ai) | 8'h01; b = val(bi);
                ea = {a, b};
                prep(8'h35, a, b);
                go();
                rd(16'h0007, r7);
                chk("R6 indirect load", 16'(r7), 16'(model[ea[MEM_AW-1:0]]));
            end
        end

        // R7: indirect store to {[11],[10]} via r10 (even)
        for (int ai = 0; ai < 8; ai++) begin
            for (int bi = 0; bi < 8; bi++) begin
                logic [7:0] a, hi, lo;
                a = val(ai); lo = val(bi); hi = 8'(1 + ai % 3);
                prep(8'h53, a, 8'h00);
                wr(16'h000A, lo); wr(16'h000B, hi);
                go();
                model[{hi[1:0], lo}] = a;
                rd({hi, lo}, m);
                chk("R7 indirect store", 16'(m), 16'(a));
            end
        end

        // R8: port exchange
        for (int ai = 0; ai < 8; ai++) begin
            for (int ib = 0; ib < 4; ib++) begin
                logic [7:0] a;
                a = val(ai);
                prep(8'h0B, a, 8'h00);
                in_bits = 2'(ib);
                go();
                chk("R8 out_port gets X", 16'(out_port), 16'(a));
                rd(16'h0007, r7);
                chk("R8 X gets inputs", 16'(r7), 16'(ib));
            end
        end

        // R9: nibble shift with literal
        for (int ai = 0; ai < 8; ai++) begin
            for (int n = 0; n < 16; n++) begin
                logic [7:0] a;
                a = val(ai);
                prep({4'(n), 4'b0111}, a, 8'h00);
                go();
                rd(16'h0007, r7);
                chk("R9 nibble literal", 16'(r7), 16'({4'(n), a[7:4]}));
            end
        end

        // R10, R11: conditional jump (r17 = 10001b), self-jump halts
        for (int ai = 0; ai < 8; ai++) begin
            logic [7:0] a;
            a = val(ai);
            prep(8'h8F, a, 8'h00);
            go();
            rd(16'h0007, r7);
            chk("R10 jump taken only on zero", 16'(r7), (a == 8'h00) ? 16'h00EE : 16'(a));
            rd(16'h0000, p0);
            rd(16'h0001, p1);
            chk("R11 pointer at self-jump", {p1, p0}, 16'h0044);
            repeat (5) @(negedge clk);
            chk("R11 halt holds", 16'(halt), 16'd1);
        end

        // R2: sequential execution across the 0x1FF/0x200 boundary
        hold_reset();
        wr(16'h0000, 8'hFE); wr(16'h0001, 8'h01);
        wr(16'h0002, 8'h01); wr(16'h0011, 8'h02);
        wr(16'h0008, 8'h00); wr(16'h0005, 8'h5A); wr(16'h0007, 8'hEE);
        wr(16'h01FE, 8'h2E); wr(16'h01FF, 8'h39);
        wr(16'h0200, 8'h46); wr(16'h0201, 8'h8F);
        go();
        rd(16'h0007, r7);
        chk("R2 order across page", 16'(r7), 16'h005A);
        rd(16'h0000, p0);
        rd(16'h0001, p1);
        chk("R2 pointer high byte carry", {p1, p0}, 16'h0201);

        // R12: full memory image above the register page
        bad = 0;
        for (int i = 256; i < DEPTH; i++) begin
            rd(16'(i), m);
            if (m !== model[i]) bad++;
        end
        chk("R12 memory image mismatches", 16'(bad), 16'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1520000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule